// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a page-granular page table entry by walking a radix page table held in memory. A walk begins when `start_i` is seen while the walker is idle. The walker first checks that the address is properly sign-extended. It then reads one entry per level through a single-outstanding request/response memory port. The first read is taken from the root base input, and each later read from the page named by the previous pointer entry. At every level the walk descends, stops with a fault, or stops on a leaf.

A leaf found above the last level maps a superpage. The walker merges the virtual page number bits that such a leaf leaves uncovered into the returned entry, so a translation cache that holds only single pages can store the result directly. Every entry address and the final physical page are checked against the memory size. The result, or a fault with an all-zero entry, is presented with a one-cycle `done_o` pulse. Permission checking and translation caching belong to other blocks.

The controller has four states. `S_IDLE` waits for a start. `S_REQ` presents the read for the current level. `S_WAIT` waits for the read data. `S_FIN` signals completion. The transitions are:
- `S_IDLE`→`S_REQ` on a start with a sign-extended address.
- `S_IDLE`→`S_FIN` on a start with a badly extended address.
- `S_REQ`→`S_WAIT` when the read is accepted.
- `S_REQ`→`S_FIN` when the entry address is out of range.
- `S_WAIT`→`S_REQ` on a pointer entry above the last level.
- `S_WAIT`→`S_FIN` on an invalid entry, a leaf, or a pointer at the last level.
- `S_FIN`→`S_IDLE` always.

Top module: `page_walker`

## Requirements
- R1: While reset is held and after it is released, the walker is idle: `busy_o`, `done_o` and `mem_req_valid_o` are low.
- R2: A start whose address bits from bit VA_BITS-1 up to the top are neither all zero nor all one finishes with `fault_o` high and issues no memory read. VA_BITS equals PG_SHIFT + LEVELS*IDX_BITS.
- R3: At level L (0 = first), the shift is S = (LEVELS-1-L)*IDX_BITS. The read address is base + idx*PTE_BYTES, where idx is the IDX_BITS-wide address field starting at bit PG_SHIFT+S. The base at level 0 is `root_base_i`.
- R4: When the read address of a level is at or beyond MEM_BYTES, the walk ends with a fault and that read is never requested.
- R5: An entry whose bit 0 (valid) is clear ends the walk with a fault.
- R6: An entry with bit 0 set and bit 1 (table) set, found above the last level, is a pointer. The next level's base is the entry with its low PG_SHIFT bits cleared.
- R7: An entry with bit 0 set and bit 1 clear is a leaf. The result is that entry OR'd with (virtual page number mod 2^S) shifted left by PG_SHIFT, where the virtual page number is the address shifted right by PG_SHIFT. `fault_o` is low.
- R8: When the leaf result with its low PG_SHIFT bits cleared is at or beyond MEM_BYTES, the walk ends with a fault.
- R9: A pointer entry at the last level ends the walk with a fault.
- R10: A read request holds its valid and address until accepted. No new request is made until the response has arrived. Exactly one read is made per level visited.
- R11: `busy_o` is high from the cycle after an accepted start through the cycle that `done_o` is high. `done_o` lasts one cycle. A start seen while busy is ignored.
- R12: Whenever `fault_o` is reported with `done_o`, `pte_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| vaddr_i | input | XLEN | Virtual address to translate |
| root_base_i | input | XLEN | Byte address of the first-level table |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk ended without a usable mapping |
| pte_o | output | XLEN | Page-granular result entry (zero on fault) |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_addr_o | output | XLEN | Byte address of the entry to read |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Read data is present |
| mem_rsp_data_i | input | XLEN | Entry read from memory |

## Verification
The hardest outcomes to reach from the ports lie at the deepest levels: a pointer at the last level, a pointer that leads to a table beyond memory, and a superpage leaf whose merged page falls outside memory. Each needs a chain of particular entries stored in memory. The bench therefore uses a tiny configuration (32-byte pages, four entries per table, three levels, 1 KiB of memory). It fills every table slot in memory with a pseudo-random mix of invalid, pointer and leaf entries whose page numbers run slightly past the end of memory. It then sweeps every sign-extended virtual address against several root tables, so that all walk outcomes occur many times under a stalling memory port.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_REQ,
        S_WAIT,
        S_FIN
    } walk_state_t;

    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_TABLE_BIT = 1;
endpackage

// File: rtl/ptw_canon.sv
// Sign-extension check on the bits at and above the top virtual-address bit.
module ptw_canon #(
    parameter int XLEN    = 64,
    parameter int VA_BITS = 39
) (
    input  logic [XLEN-VA_BITS:0] va_top,
    output logic                  canon_ok
);
    generate
        if (VA_BITS >= XLEN) begin : g_full
            assign canon_ok = 1'b1;
        end else begin : g_check
            assign canon_ok = (&va_top) | ~(|va_top);
        end
    endgenerate
endmodule

// File: rtl/ptw_index.sv
// Entry address for the current level and its range check.
module ptw_index #(
    parameter int              XLEN      = 64,
    parameter int              PG_SHIFT  = 12,
    parameter int              IDX_BITS  = 9,
    parameter int              PTE_BYTES = 8,
    parameter longint unsigned MEM_BYTES = 64'h4000_0000,
    parameter int              SH_W      = 8
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] vaddr,
    input  logic [SH_W-1:0] shift,
    output logic [XLEN-1:0] entry_addr,
    output logic            entry_in_mem
);
    localparam logic [XLEN-1:0] IDX_MASK = (XLEN'(1) << IDX_BITS) - XLEN'(1);

    logic [XLEN-1:0] idx;

    always_comb begin
        idx          = (vaddr >> (PG_SHIFT + int'(shift))) & IDX_MASK;
        entry_addr   = base + idx * XLEN'(PTE_BYTES);
        entry_in_mem = entry_addr < XLEN'(MEM_BYTES);
    end
endmodule

// File: rtl/ptw_leaf.sv
// Folds uncovered page-number bits into a leaf and checks its physical page.
module ptw_leaf #(
    parameter int              XLEN      = 64,
    parameter int              PG_SHIFT  = 12,
    parameter longint unsigned MEM_BYTES = 64'h4000_0000,
    parameter int              SH_W      = 8
) (
    input  logic [XLEN-1:0] entry,
    input  logic [XLEN-1:0] vaddr,
    input  logic [SH_W-1:0] shift,
    output logic [XLEN-1:0] leaf_pte,
    output logic            leaf_in_mem
);
    localparam logic [XLEN-1:0] OFF_MASK = (XLEN'(1) << PG_SHIFT) - XLEN'(1);

    logic [XLEN-1:0] vpn;
    logic [XLEN-1:0] low_mask;

    always_comb begin
        vpn         = vaddr >> PG_SHIFT;
        low_mask    = (XLEN'(1) << shift) - XLEN'(1);
        leaf_pte    = entry | ((vpn & low_mask) << PG_SHIFT);
        leaf_in_mem = (leaf_pte & ~OFF_MASK) < XLEN'(MEM_BYTES);
    end
endmodule

// File: rtl/page_walker.sv
module page_walker
    import ptw_pkg::*;
#(
    parameter int              XLEN      = 64,
    parameter int              PG_SHIFT  = 12,
    parameter int              IDX_BITS  = 9,
    parameter int              LEVELS    = 3,
    parameter int              PTE_BYTES = 8,
    parameter longint unsigned MEM_BYTES = 64'h4000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [XLEN-1:0] vaddr_i,
    input  logic [XLEN-1:0] root_base_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            fault_o,
    output logic [XLEN-1:0] pte_o,
    output logic            mem_req_valid_o,
    output logic [XLEN-1:0] mem_req_addr_o,
    input  logic            mem_req_ready_i,
    input  logic            mem_rsp_valid_i,
    input  logic [XLEN-1:0] mem_rsp_data_i
);
    localparam int VA_BITS = PG_SHIFT + LEVELS * IDX_BITS;
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int SH_W    = 8;
    localparam logic [XLEN-1:0] OFF_MASK = (XLEN'(1) << PG_SHIFT) - XLEN'(1);

    walk_state_t      state_q, state_d;
    logic [LVL_W-1:0] lvl_q, lvl_d;
    logic [XLEN-1:0]  base_q, base_d;
    logic [XLEN-1:0]  va_q, va_d;
    logic [XLEN-1:0]  res_q, res_d;
    logic             flt_q, flt_d;

    logic [SH_W-1:0]  cur_shift;
    logic             canon_ok;
    logic [XLEN-1:0]  entry_addr;
    logic             entry_in_mem;
    logic [XLEN-1:0]  leaf_pte;
    logic             leaf_in_mem;
    logic             last_lvl;

    assign cur_shift = SH_W'((LEVELS - 1 - int'(lvl_q)) * IDX_BITS);
    assign last_lvl  = (lvl_q == LVL_W'(LEVELS - 1));

    ptw_canon #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_canon (
        .va_top   (vaddr_i[XLEN-1:VA_BITS-1]),
        .canon_ok (canon_ok)
    );

    ptw_index #(
        .XLEN(XLEN), .PG_SHIFT(PG_SHIFT), .IDX_BITS(IDX_BITS),
        .PTE_BYTES(PTE_BYTES), .MEM_BYTES(MEM_BYTES), .SH_W(SH_W)
    ) u_index (
        .base         (base_q),
        .vaddr        (va_q),
        .shift        (cur_shift),
        .entry_addr   (entry_addr),
        .entry_in_mem (entry_in_mem)
    );

    ptw_leaf #(
        .XLEN(XLEN), .PG_SHIFT(PG_SHIFT), .MEM_BYTES(MEM_BYTES), .SH_W(SH_W)
    ) u_leaf (
        .entry       (mem_rsp_data_i),
        .vaddr       (va_q),
        .shift       (cur_shift),
        .leaf_pte    (leaf_pte),
        .leaf_in_mem (leaf_in_mem)
    );

    // State register and walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            lvl_q   <= '0;
            base_q  <= '0;
            va_q    <= '0;
            res_q   <= '0;
            flt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
            base_q  <= base_d;
            va_q    <= va_d;
            res_q   <= res_d;
            flt_q   <= flt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        base_d  = base_q;
        va_d    = va_q;
        res_d   = res_q;
        flt_d   = flt_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    va_d   = vaddr_i;
                    base_d = root_base_i;
                    lvl_d  = '0;
                    res_d  = '0;
                    flt_d  = !canon_ok;
                    state_d = canon_ok ? S_REQ : S_FIN;
                end
            end
            S_REQ: begin
                if (!entry_in_mem) begin
                    flt_d   = 1'b1;
                    state_d = S_FIN;
                end else if (mem_req_ready_i) begin
                    state_d = S_WAIT;
                end
            end
            S_WAIT: begin
                if (mem_rsp_valid_i) begin
                    if (!mem_rsp_data_i[PTE_VALID_BIT]) begin
                        flt_d   = 1'b1;
                        state_d = S_FIN;
                    end else if (mem_rsp_data_i[PTE_TABLE_BIT]) begin
                        if (last_lvl) begin
                            flt_d   = 1'b1;
                            state_d = S_FIN;
                        end else begin
                            base_d  = mem_rsp_data_i & ~OFF_MASK;
                            lvl_d   = lvl_q + LVL_W'(1);
                            state_d = S_REQ;
                        end
                    end else begin
                        if (leaf_in_mem) begin
                            res_d = leaf_pte;
                        end else begin
                            flt_d = 1'b1;
                        end
                        state_d = S_FIN;
                    end
                end
            end
            S_FIN: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o          = (state_q != S_IDLE);
        done_o          = (state_q == S_FIN);
        fault_o         = flt_q;
        pte_o           = res_q;
        mem_req_valid_o = (state_q == S_REQ) && entry_in_mem;
        mem_req_addr_o  = entry_addr;
    end
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int              XLEN      = 64,
    parameter int              VA_BITS   = 39,
    parameter longint unsigned MEM_BYTES = 64'h4000_0000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic [XLEN-VA_BITS:0] va_top,
    input logic                  busy_o,
    input logic                  done_o,
    input logic                  fault_o,
    input logic [XLEN-1:0]       pte_o,
    input logic                  mem_req_valid_o,
    input logic [XLEN-1:0]       mem_req_addr_o,
    input logic                  mem_req_ready_i
);
    logic bad_ext;
    assign bad_ext = !((&va_top) || !(|va_top));

    assert_badext_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && bad_ext) |=> (done_o && fault_o && !mem_req_valid_o));

    assert_req_in_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> (mem_req_addr_o < XLEN'(MEM_BYTES)));

    assert_leaf_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o) |-> (pte_o[0] && !pte_o[1]));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_fault_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> (pte_o == '0));
endmodule

bind page_walker ptw_checker #(
    .XLEN(XLEN), .VA_BITS(VA_BITS), .MEM_BYTES(MEM_BYTES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .va_top          (vaddr_i[XLEN-1:VA_BITS-1]),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .fault_o         (fault_o),
    .pte_o           (pte_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_ready_i (mem_req_ready_i)
);

// File: tb/page_walker_tb.sv
module page_walker_tb;
    localparam int PGS = 5;
    localparam int IDXB = 2;
    localparam int LV = 3;
    localparam longint unsigned MEMB = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] vaddr_i = '0;
    logic [63:0] root_base_i = '0;
    logic        busy_o, done_o, fault_o;
    logic [63:0] pte_o;
    logic        mem_req_valid_o;
    logic [63:0] mem_req_addr_o;
    logic        mem_req_ready_i = 1'b0;
    logic        mem_rsp_valid_i = 1'b0;
    logic [63:0] mem_rsp_data_i = '0;

    always #5 clk = ~clk;

    page_walker #(
        .XLEN(64), .PG_SHIFT(PGS), .IDX_BITS(IDXB), .LEVELS(LV),
        .PTE_BYTES(8), .MEM_BYTES(MEMB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i),
        .root_base_i(root_base_i), .busy_o(busy_o), .done_o(done_o),
        .fault_o(fault_o), .pte_o(pte_o), .mem_req_valid_o(mem_req_valid_o),
        .mem_req_addr_o(mem_req_addr_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i)
    );

    int checks = 0;
    int errors = 0;
    logic [63:0] tmem [0:127];
    logic [31:0] lcg = 32'h1234_5678;

    // Expected walk
    logic [63:0] exp_addr [0:3];
    int          exp_n;
    logic        exp_flt;
    logic [63:0] exp_pte;
    int          exp_why;
    int          exp_lvl;
    int          hits [0:12];

    // Memory model state
    int          req_cnt = 0;
    logic        pend = 1'b0;
    logic [63:0] pend_a = '0;
    int          cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return {16'd0, lcg[30:15]};
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (mem_rsp_valid_i) mem_rsp_valid_i = 1'b0;
        if (pend) begin
            mem_rsp_valid_i = 1'b1;
            mem_rsp_data_i  = tmem[pend_a[9:3]];
            pend = 1'b0;
        end
        mem_req_ready_i = (cyc % 4) != 2;
        if (rst_n && mem_req_valid_o && mem_req_ready_i) begin
            checks++;
            if (req_cnt >= exp_n) begin
                errors++;
                $display("FAIL R10 extra read actual=%h expected=none", mem_req_addr_o);
            end else if (mem_req_addr_o != exp_addr[req_cnt]) begin
                errors++;
                if (req_cnt == 0)
                    $display("FAIL R3 read address actual=%h expected=%h", mem_req_addr_o, exp_addr[req_cnt]);
                else
                    $display("FAIL R6 descended read address actual=%h expected=%h", mem_req_addr_o, exp_addr[req_cnt]);
            end
            pend   = 1'b1;
            pend_a = mem_req_addr_o;
            req_cnt++;
        end
    end

    // Reference walk from the requirements
    task automatic ref_walk(input logic [63:0] va, input logic [63:0] root);
        logic [63:0] base, a, d, vpn, top;
        int sh;
        bit stop;
        exp_n = 0; exp_flt = 1'b1; exp_pte = '0; exp_why = 0; exp_lvl = 0;
        top = va >> (PGS + LV*IDXB - 1);
        if (!(top == 64'd0 || top == ({64{1'b1}} >> (PGS + LV*IDXB - 1)))) begin
            exp_why = 2;
            return;
        end
        base = root; stop = 0;
        for (int lvl = 0; lvl < LV && !stop; lvl++) begin
            sh = (LV - 1 - lvl) * IDXB;
            exp_lvl = lvl;
            a = base + ((va >> (PGS + sh)) & ((64'd1 << IDXB) - 1)) * 8;
            if (a >= MEMB) begin exp_why = 4; stop = 1; end
            else begin
                exp_addr[exp_n] = a; exp_n++;
                d = tmem[a[9:3]];
                if (!d[0]) begin exp_why = 5; stop = 1; end
                else if (d[1]) begin
                    if (lvl == LV - 1) begin exp_why = 9; stop = 1; end
                    else base = (d >> PGS) << PGS;
                end else begin
                    vpn = va >> PGS;
                    d = d | ((vpn & ((64'd1 << sh) - 1)) << PGS);
                    if (((d >> PGS) << PGS) >= MEMB) exp_why = 8;
                    else begin exp_why = 7; exp_flt = 1'b0; exp_pte = d; end
                    stop = 1;
                end
            end
        end
    endtask

    task automatic fill_tables();
        for (int s = 0; s < 128; s++) begin
            logic [31:0] r, r2;
            logic [63:0] ppn;
            r = rnd(); r2 = rnd();
            ppn = 64'(r2 % 36);
            if (r % 8 < 2)       tmem[s] = {51'(r2), 2'(r), 10'd0, 1'b0} & ~64'd1;
            else if (r % 8 < 5)  tmem[s] = (ppn << PGS) | 64'd3 | 64'((r2 >> 8) & 28);
            else                 tmem[s] = (ppn << PGS) | 64'd1 | 64'((r2 >> 8) & 28);
        end
    endtask

    task automatic walk_one(input logic [63:0] va, input logic [63:0] root);
        bit got;
        int k;
        string tag;
        ref_walk(va, root);
        hits[exp_why]++;
        if (exp_why == 7 && exp_lvl < LV - 1) hits[6]++;
        tag = $sformatf("R%0d", exp_why);
        req_cnt = 0;
        start_i = 1'b1; vaddr_i = va; root_base_i = root;
        got = 0; k = 0;
        forever begin
            @(negedge clk);
            k++;
            if (k > 100) begin
                errors++;
                $display("FAIL R11 watchdog expired actual=busy expected=done");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
            if (k == 1) chk(busy_o == 1'b1, "R11 busy after start", 64'(busy_o), 64'd1);
            if (got) begin
                chk(!done_o && !busy_o, "R11 single done then idle", {62'd0, done_o, busy_o}, 64'd0);
                start_i = 1'b0;
                break;
            end
            if (done_o) begin
                got = 1;
                chk(fault_o == exp_flt, {tag, " fault flag"}, 64'(fault_o), 64'(exp_flt));
                chk(pte_o == exp_pte, exp_flt ? "R12 zero entry on fault" : {tag, " leaf entry"}, pte_o, exp_pte);
                chk(req_cnt == exp_n, "R10 reads per walk", 64'(req_cnt), 64'(exp_n));
            end
            start_i = (k == 1);
            if (k == 1) vaddr_i = ~va;
        end
    endtask

    initial begin
        logic [63:0] roots [0:3];
        for (int i = 0; i < 13; i++) hits[i] = 0;
        exp_n = 0;
        roots[0] = 64'd32; roots[1] = 64'd224; roots[2] = 64'd640; roots[3] = 64'd1100;
        fill_tables();
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !mem_req_valid_o, "R1 idle in reset",
            {61'd0, busy_o, done_o, mem_req_valid_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !mem_req_valid_o, "R1 idle after reset",
            {61'd0, busy_o, done_o, mem_req_valid_o}, 64'd0);
        for (int c = 0; c < 3; c++) begin
            for (int i = 0; i < 2048; i++) begin
                logic [10:0] low;
                low = 11'(i);
                walk_one({{53{low[10]}}, low}, roots[c]);
            end
            for (int j = 0; j < 8; j++) begin
                walk_one((64'd1 << (11 + j * 6)) | 64'(j * 37), roots[c]);
                walk_one(~(64'd1 << (12 + j * 6)) & ~64'h7ff | 64'(j), roots[c]);
            end
        end
        for (int i = 0; i < 16; i++) walk_one(64'(i * 97), roots[3]);
        chk(hits[2] > 0, "R2 coverage", 64'(hits[2]), 64'd1);
        chk(hits[4] > 0, "R4 coverage", 64'(hits[4]), 64'd1);
        chk(hits[5] > 0, "R5 coverage", 64'(hits[5]), 64'd1);
        chk(hits[6] > 0, "R7 superpage coverage", 64'(hits[6]), 64'd1);
        chk(hits[7] > 0, "R7 leaf coverage", 64'(hits[7]), 64'd1);
        chk(hits[8] > 0, "R8 coverage", 64'(hits[8]), 64'd1);
        chk(hits[9] > 0, "R9 coverage", 64'(hits[9]), 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule